// File: doc/BRIEF.md
# Capped In-Order Micro-op Dispatcher

This block sits between a rename stage and eight per-pipeline issue queues. Rename hands it a group of up to five micro-ops at once. Each micro-op carries an age tag and a pipeline class code. The group is captured in a holding register. On each following cycle the block sends as many of the held micro-ops as it can to their issue queues. Slot 0 is the oldest, and the block walks the slots strictly in that order.

Every pipeline class has its own per-cycle cap. A micro-op whose cap is already used up in the cycle, or whose queue reports full, stops the walk. Nothing younger in the group may pass it, and it is tried again on the next cycle. Rename is held off until every micro-op of the current group has left. A flush input drops whatever is held and suppresses dispatch in that same cycle.

Integer micro-ops are spread over the two integer queues. The queue that receives the older integer micro-op alternates from one dispatching cycle to the next. The block reports how many micro-ops it dispatched in each cycle.

Top module: `uop_dispatch`

## Requirements
- R1: A group is captured at a rising edge where `in_valid` and `in_ready` are both high. Slot k holds a micro-op when `in_mask[k]` is 1, and slot 0 is the oldest. The captured micro-ops become dispatch candidates from the next cycle on.
- R2: The class codes are 0 branch, 1 integer, 2 multi-cycle, 3 float pipe 0, 4 float pipe 1, 5 load and 6 store. The queue indices are 0 branch, 1 integer 0, 2 integer 1, 3 multi-cycle, 4 float 0, 5 float 1, 6 load and 7 store. Lane l of queue q is bit q*2+l of `q_vld`, and its age tag sits in field q*2+l of `q_age`. Lane 0 carries the older micro-op. Every micro-op reaches the queue of its class. `disp_cnt` equals the number of lanes that are valid, and it never exceeds five.
- R3: At most one branch micro-op is dispatched per cycle.
- R4: At most two integer micro-ops are dispatched per cycle, and each uses lane 0 of queue 1 or queue 2. After reset, the older one goes to queue 1. The queue that takes the older one swaps after every cycle that dispatches any integer micro-op.
- R5: At most two multi-cycle micro-ops are dispatched per cycle.
- R6: At most one micro-op is dispatched per cycle to each float queue.
- R7: At most two load and store micro-ops combined are dispatched per cycle.
- R8: In each cycle, the dispatched micro-ops are exactly the k oldest micro-ops still held, where k is the dispatch count. A blocked micro-op stops every younger one.
- R9: No lane of a queue whose `q_full` bit is high is valid. A micro-op bound for that queue waits.
- R10: `in_ready` is high exactly when `flush` is low and no held micro-op remains after this cycle's dispatch.
- R11: While `flush` is high, `q_vld` is zero and `in_ready` is low. In the next cycle nothing is held.
- R12: After reset, nothing is held, `in_ready` is high and `q_vld` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard held micro-ops, dispatch nothing |
| in_valid | input | 1 | Rename offers a group |
| in_ready | output | 1 | Group accepted this cycle |
| in_mask | input | SLOTS | Per-slot occupancy, slot 0 oldest |
| in_cls | input | SLOTS*3 | Class code per slot |
| in_age | input | SLOTS*AGE_W | Age tag per slot |
| q_full | input | 8 | Per-queue full flag |
| q_vld | output | 16 | Per-queue, per-lane dispatch valid |
| q_age | output | 16*AGE_W | Age tag on each lane |
| disp_cnt | output | $clog2(SLOTS+1) | Micro-ops dispatched this cycle |

## Verification
Suppose the held-slot mask goes stale. A slot that was already sent is then sent again and shows up as a repeated age tag. A slot that was wrongly cleared makes the group drain one cycle early. Either fault is visible on the first dispatch cycle after it happens. A broken cap count or blocking chain shows up as a lane appearing in the same cycle as the fault, or as an age tag appearing ahead of an older one still held. A wrong integer pointer puts the older integer tag on the wrong queue at that pointer's next use.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int NQ     = 8;
  localparam int LANES  = 2;
  localparam int CLS_W  = 3;
  localparam int QID_W  = 3;
  localparam int NLANE  = NQ * LANES;

  typedef enum logic [CLS_W-1:0] {
    C_BR  = 3'd0,
    C_INT = 3'd1,
    C_MC  = 3'd2,
    C_FP0 = 3'd3,
    C_FP1 = 3'd4,
    C_LD  = 3'd5,
    C_ST  = 3'd6
  } uop_cls_e;

  localparam logic [QID_W-1:0] Q_BR   = 3'd0;
  localparam logic [QID_W-1:0] Q_INT0 = 3'd1;
  localparam logic [QID_W-1:0] Q_INT1 = 3'd2;
  localparam logic [QID_W-1:0] Q_MC   = 3'd3;
  localparam logic [QID_W-1:0] Q_FP0  = 3'd4;
  localparam logic [QID_W-1:0] Q_FP1  = 3'd5;
  localparam logic [QID_W-1:0] Q_LD   = 3'd6;
  localparam logic [QID_W-1:0] Q_ST   = 3'd7;

  localparam int CAP_BR  = 1;
  localparam int CAP_INT = 2;
  localparam int CAP_MC  = 2;
  localparam int CAP_FP0 = 1;
  localparam int CAP_FP1 = 1;
  localparam int CAP_LS  = 2;

  // flat lane number of a queue/lane pair
  function automatic int lane_of(logic [QID_W-1:0] q, logic ln);
    return int'(q) * LANES + int'(ln);
  endfunction

  // integer queue picked for the n-th integer op of a cycle
  function automatic logic [QID_W-1:0] int_queue(logic ptr, int n_int);
    return (ptr ^ (n_int != 0)) ? Q_INT1 : Q_INT0;
  endfunction
endpackage

// File: rtl/disp_group_reg.sv
module disp_group_reg
  import disp_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int AGE_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              flush,
  input  logic                              load,
  input  logic [SLOTS-1:0]                  in_mask,
  input  logic [SLOTS*CLS_W-1:0]            in_cls,
  input  logic [SLOTS*AGE_W-1:0]            in_age,
  input  logic [SLOTS-1:0]                  sent,
  output logic [SLOTS-1:0]                  held_vld,
  output logic [SLOTS-1:0][CLS_W-1:0]       held_cls,
  output logic [SLOTS-1:0][AGE_W-1:0]       held_age
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_vld <= '0;
      held_cls <= '0;
      held_age <= '0;
    end else if (flush) begin
      held_vld <= '0;
    end else if (load) begin
      held_vld <= in_mask;
      held_cls <= in_cls;
      held_age <= in_age;
    end else begin
      held_vld <= held_vld & ~sent;
    end
  end
endmodule

// File: rtl/disp_select.sv
module disp_select
  import disp_pkg::*;
#(
  parameter int SLOTS    = 5,
  parameter int MAX_DISP = 5
) (
  input  logic                        en,
  input  logic                        int_ptr,
  input  logic [SLOTS-1:0]            held_vld,
  input  logic [SLOTS-1:0][CLS_W-1:0] held_cls,
  input  logic [NQ-1:0]               q_full,
  output logic [SLOTS-1:0]            go,
  output logic [SLOTS-1:0][QID_W-1:0] slot_q,
  output logic [SLOTS-1:0]            slot_ln,
  output logic                        int_any
);
  always_comb begin
    int n_br, n_int, n_mc, n_f0, n_f1, n_ld, n_st, n_tot;
    logic stop, ok, ln;
    logic [QID_W-1:0] q;
    n_br = 0; n_int = 0; n_mc = 0; n_f0 = 0; n_f1 = 0;
    n_ld = 0; n_st = 0; n_tot = 0;
    stop    = !en;
    go      = '0;
    slot_q  = '0;
    slot_ln = '0;
    int_any = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      ok = 1'b0;
      ln = 1'b0;
      q  = Q_BR;
      case (uop_cls_e'(held_cls[i]))
        C_INT: begin ok = n_int < CAP_INT; q = int_queue(int_ptr, n_int); end
        C_MC:  begin ok = n_mc < CAP_MC;   q = Q_MC;  ln = n_mc != 0; end
        C_FP0: begin ok = n_f0 < CAP_FP0;  q = Q_FP0; ln = n_f0 != 0; end
        C_FP1: begin ok = n_f1 < CAP_FP1;  q = Q_FP1; ln = n_f1 != 0; end
        C_LD:  begin ok = (n_ld + n_st) < CAP_LS; q = Q_LD; ln = n_ld != 0; end
        C_ST:  begin ok = (n_ld + n_st) < CAP_LS; q = Q_ST; ln = n_st != 0; end
        default: begin ok = n_br < CAP_BR; q = Q_BR; ln = n_br != 0; end
      endcase
      ok = ok && !q_full[q] && (n_tot < MAX_DISP);
      slot_q[i]  = q;
      slot_ln[i] = ln;
      if (held_vld[i] && !stop) begin
        if (ok) begin
          go[i] = 1'b1;
          n_tot = n_tot + 1;
          case (uop_cls_e'(held_cls[i]))
            C_INT: begin n_int = n_int + 1; int_any = 1'b1; end
            C_MC:  n_mc = n_mc + 1;
            C_FP0: n_f0 = n_f0 + 1;
            C_FP1: n_f1 = n_f1 + 1;
            C_LD:  n_ld = n_ld + 1;
            C_ST:  n_st = n_st + 1;
            default: n_br = n_br + 1;
          endcase
        end else begin
          stop = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/disp_route.sv
module disp_route
  import disp_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int AGE_W = 8,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SLOTS-1:0]            go,
  input  logic [SLOTS-1:0][QID_W-1:0] slot_q,
  input  logic [SLOTS-1:0]            slot_ln,
  input  logic [SLOTS-1:0][AGE_W-1:0] held_age,
  input  logic                        int_any,
  output logic                        int_ptr,
  output logic [NLANE-1:0]            q_vld,
  output logic [NLANE*AGE_W-1:0]      q_age,
  output logic [CNT_W-1:0]            disp_cnt
);
  always_comb begin
    int idx;
    q_vld = '0;
    q_age = '0;
    for (int i = 0; i < SLOTS; i++) begin
      idx = lane_of(slot_q[i], slot_ln[i]);
      if (go[i]) begin
        q_vld[idx]                 = 1'b1;
        q_age[idx*AGE_W +: AGE_W]  = held_age[i];
      end
    end
    disp_cnt = CNT_W'($countones(go));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       int_ptr <= 1'b0;
    else if (int_any) int_ptr <= ~int_ptr;
  end
endmodule

// File: rtl/uop_dispatch.sv
module uop_dispatch
  import disp_pkg::*;
#(
  parameter int SLOTS    = 5,
  parameter int AGE_W    = 8,
  parameter int MAX_DISP = 5,
  localparam int CNT_W   = $clog2(SLOTS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [SLOTS-1:0]           in_mask,
  input  logic [SLOTS*CLS_W-1:0]     in_cls,
  input  logic [SLOTS*AGE_W-1:0]     in_age,
  input  logic [NQ-1:0]              q_full,
  output logic [NLANE-1:0]           q_vld,
  output logic [NLANE*AGE_W-1:0]     q_age,
  output logic [CNT_W-1:0]           disp_cnt
);
  logic [SLOTS-1:0]            held_vld;
  logic [SLOTS-1:0][CLS_W-1:0] held_cls;
  logic [SLOTS-1:0][AGE_W-1:0] held_age;
  logic [SLOTS-1:0]            sel_go;
  logic [SLOTS-1:0][QID_W-1:0] sel_q;
  logic [SLOTS-1:0]            sel_ln;
  logic                        int_any;
  logic                        int_ptr;
  logic                        grp_done;
  logic                        grp_load;

  assign grp_done = ((held_vld & ~sel_go) == '0);
  assign in_ready = !flush && grp_done;
  assign grp_load = in_valid && in_ready;

  disp_group_reg #(.SLOTS(SLOTS), .AGE_W(AGE_W)) u_grp (
    .clk(clk), .rst_n(rst_n), .flush(flush), .load(grp_load),
    .in_mask(in_mask), .in_cls(in_cls), .in_age(in_age), .sent(sel_go),
    .held_vld(held_vld), .held_cls(held_cls), .held_age(held_age)
  );

  disp_select #(.SLOTS(SLOTS), .MAX_DISP(MAX_DISP)) u_sel (
    .en(!flush), .int_ptr(int_ptr), .held_vld(held_vld), .held_cls(held_cls),
    .q_full(q_full), .go(sel_go), .slot_q(sel_q), .slot_ln(sel_ln),
    .int_any(int_any)
  );

  disp_route #(.SLOTS(SLOTS), .AGE_W(AGE_W)) u_route (
    .clk(clk), .rst_n(rst_n), .go(sel_go), .slot_q(sel_q), .slot_ln(sel_ln),
    .held_age(held_age), .int_any(int_any), .int_ptr(int_ptr),
    .q_vld(q_vld), .q_age(q_age), .disp_cnt(disp_cnt)
  );
endmodule

// File: rtl/dispatch_chk.sv
module dispatch_chk
  import disp_pkg::*;
#(
  parameter int SLOTS    = 5,
  parameter int MAX_DISP = 5,
  localparam int CNT_W   = $clog2(SLOTS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             in_ready,
  input logic [NQ-1:0]    q_full,
  input logic [NLANE-1:0] q_vld,
  input logic [CNT_W-1:0] disp_cnt
);
  // R2
  cnt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(disp_cnt) == $countones(q_vld)) && (int'(disp_cnt) <= MAX_DISP));
  // R3
  br_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(q_vld[Q_BR*LANES +: LANES]) <= CAP_BR);
  // R4
  int_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_vld[Q_INT0*LANES+1] && !q_vld[Q_INT1*LANES+1]);
  // R6
  fp_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_vld[Q_FP0*LANES+1] && !q_vld[Q_FP1*LANES+1]);
  // R7
  ls_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(q_vld[Q_LD*LANES +: 2*LANES]) <= CAP_LS);
  // R11
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (q_vld == '0) && !in_ready);
  // R11
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (flush || in_ready));

  for (genvar g = 0; g < NQ; g++) begin : g_full
    // R9
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_full[g] |-> (q_vld[g*LANES +: LANES] == '0));
  end
endmodule

bind uop_dispatch dispatch_chk #(.SLOTS(SLOTS), .MAX_DISP(MAX_DISP)) u_dispatch_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_ready(in_ready),
  .q_full(q_full), .q_vld(q_vld), .disp_cnt(disp_cnt)
);

// File: tb/test_uop_dispatch.sv
module test_uop_dispatch;
  localparam int SLOTS = 5;
  localparam int AGE_W = 8;
  localparam int NV    = 8;

  // stimulus table: mask, classes {s4..s0}, expected first-cycle count, drain cycles
  localparam logic [4:0]  V_MASK  [NV] = '{5'b11111, 5'b11111, 5'b11111, 5'b11111,
                                           5'b11111, 5'b11111, 5'b00101, 5'b11111};
  localparam logic [14:0] V_CLS   [NV] = '{
    {3'd5,3'd4,3'd3,3'd2,3'd1}, {3'd1,3'd1,3'd1,3'd0,3'd0},
    {3'd2,3'd2,3'd5,3'd6,3'd5}, {3'd0,3'd4,3'd4,3'd3,3'd3},
    {3'd1,3'd1,3'd2,3'd2,3'd2}, {3'd0,3'd5,3'd5,3'd1,3'd1},
    {3'd0,3'd0,3'd0,3'd1,3'd0}, {3'd6,3'd6,3'd6,3'd6,3'd6}};
  localparam int V_FIRST [NV] = '{5, 1, 2, 1, 2, 5, 1, 2};
  localparam int V_DRAIN [NV] = '{1, 3, 2, 3, 2, 1, 2, 3};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, flush, in_valid, in_ready;
  logic [SLOTS-1:0] in_mask;
  logic [SLOTS*3-1:0] in_cls;
  logic [SLOTS*AGE_W-1:0] in_age;
  logic [7:0] q_full;
  logic [15:0] q_vld;
  logic [16*AGE_W-1:0] q_age;
  logic [2:0] disp_cnt;

  uop_dispatch i_uop_dispatch (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_mask(in_mask), .in_cls(in_cls), .in_age(in_age), .q_full(q_full),
    .q_vld(q_vld), .q_age(q_age), .disp_cnt(disp_cnt)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int base = 0;
  logic ptr = 1'b0;
  logic [4:0] rem;
  logic [14:0] cur_cls;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic int home_q(input logic [2:0] c);
    case (c)
      3'd0: return 0; 3'd2: return 3; 3'd3: return 4; 3'd4: return 5;
      3'd5: return 6; 3'd6: return 7; default: return -1;
    endcase
  endfunction

  // one dispatch cycle against the held-slot model
  task automatic check_cycle();
    logic [4:0] dm = '0, em = '0;
    int ones = 0, c = 0, nq[8];
    for (int q = 0; q < 8; q++) nq[q] = 0;
    for (int l = 0; l < 16; l++) begin
      if (q_vld[l]) begin
        int age = int'(q_age[l*AGE_W +: AGE_W]);
        int slot = age - base;
        int q = l / 2;
        logic [2:0] cl = cur_cls[slot*3 +: 3];
        ones++;
        nq[q]++;
        if (cl == 3'd1) chk(q == 1 || q == 2, "R2 int queue", q, 1);
        else chk(q == home_q(cl), "R2 queue", q, home_q(cl));
        if (slot >= 0 && slot < 5) dm[slot] = 1'b1;
      end
    end
    chk(ones == int'(disp_cnt), "R2 count", int'(disp_cnt), ones);
    chk(nq[0] <= 1, "R3 branch cap", nq[0], 1);
    chk(nq[1] + nq[2] <= 2, "R4 int cap", nq[1] + nq[2], 2);
    chk(nq[3] <= 2, "R5 mc cap", nq[3], 2);
    chk(nq[4] <= 1 && nq[5] <= 1, "R6 fp cap", nq[4] + nq[5], 2);
    chk(nq[6] + nq[7] <= 2, "R7 ls cap", nq[6] + nq[7], 2);
    for (int s = 0; s < 5; s++)
      if (rem[s] && c < int'(disp_cnt)) begin em[s] = 1'b1; c++; end
    chk(dm == em, "R8 oldest first", int'(dm), int'(em));
    if (q_vld[2] && q_vld[4]) begin
      logic older = (q_age[2*AGE_W +: AGE_W] < q_age[4*AGE_W +: AGE_W]) ? 1'b0 : 1'b1;
      chk(older == ptr, "R4 alternation", int'(older), int'(ptr));
      ptr = ~ptr;
    end else if (q_vld[2] || q_vld[4]) begin
      chk(q_vld[4] == ptr, "R4 alternation", int'(q_vld[4]), int'(ptr));
      ptr = ~ptr;
    end
    rem = rem & ~dm;
  endtask

  task automatic offer(input logic [4:0] m, input logic [14:0] cl);
    base += 8;
    in_valid = 1'b1; in_mask = m; in_cls = cl;
    for (int s = 0; s < SLOTS; s++) in_age[s*AGE_W +: AGE_W] = AGE_W'(base + s);
    cur_cls = cl; rem = m;
  endtask

  task automatic run_group(input logic [4:0] m, input logic [14:0] cl,
                           input int exp_first, input int exp_drain);
    int cyc = 0, first = -1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready when idle", int'(in_ready), 1);
    offer(m, cl);
    @(negedge clk);
    in_valid = 1'b0;
    forever begin
      if (first < 0) first = int'(disp_cnt);
      check_cycle();
      cyc++;
      if (in_ready || cyc > 10) break;
      @(negedge clk);
    end
    chk(first == exp_first, "R8 first-cycle count", first, exp_first);
    chk(cyc == exp_drain, "R10 drain cycles", cyc, exp_drain);
    chk(rem == '0, "R10 group emptied", int'(rem), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; in_mask = '0;
    in_cls = '0; in_age = '0; q_full = '0; rem = '0; cur_cls = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    chk(in_ready == 1'b1, "R12 ready", int'(in_ready), 1);
    chk(q_vld == '0, "R12 no lanes", int'(q_vld), 0);
    chk(disp_cnt == '0, "R12 count", int'(disp_cnt), 0);

    for (int v = 0; v < NV; v++)
      run_group(V_MASK[v], V_CLS[v], V_FIRST[v], V_DRAIN[v]);

    // R9: full multi-cycle queue blocks slot 0 and everything behind it
    @(negedge clk);
    q_full = 8'h08;
    offer(5'b00111, {3'd0, 3'd0, 3'd3, 3'd5, 3'd2});
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 2; k++) begin
      chk(q_vld == '0, "R9 blocked by full", int'(q_vld), 0);
      chk(in_ready == 1'b0, "R10 stall while held", int'(in_ready), 0);
      @(negedge clk);
    end
    q_full = '0;
    #1;
    check_cycle();
    chk(disp_cnt == 3'd3, "R9 release", int'(disp_cnt), 3);
    chk(in_ready == 1'b1, "R10 ready on last", int'(in_ready), 1);

    // R11: flush drops held micro-ops and blocks a new group
    @(negedge clk);
    offer(5'b00111, 15'd0);
    @(negedge clk);
    in_valid = 1'b0;
    check_cycle();
    chk(disp_cnt == 3'd1, "R11 pre-flush dispatch", int'(disp_cnt), 1);
    flush = 1'b1;
    in_valid = 1'b1;
    #1;
    chk(q_vld == '0, "R11 quiet during flush", int'(q_vld), 0);
    chk(in_ready == 1'b0, "R11 not ready during flush", int'(in_ready), 0);
    @(negedge clk);
    flush = 1'b0;
    in_valid = 1'b0;
    #1;
    chk(q_vld == '0, "R11 held dropped", int'(q_vld), 0);
    chk(in_ready == 1'b1, "R11 idle after flush", int'(in_ready), 1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule